// File: doc/BRIEF.md
# Boot-Aware Address Decoder with Remap

This block is the first-level address decoder placed in front of one bus master. It splits the 32-bit address space into sixteen 256 MB banks using the top four address bits, and turns each valid request into a one-hot slave select or a decode abort. The six external chip selects, the DDR memory controller and the peripheral bridge each own fixed banks. Bank 0 holds the internal memories.

The first megabyte of bank 0 is an alias whose target moves with the boot state. Before software remaps, it points at the boot memory. That boot memory is the on-chip ROM or external chip select 0, chosen by a strap pin latched while reset is held. After a remap command, the alias points at internal SRAM so that exception vectors can be rewritten at run time. The ROM and the SRAM always stay reachable at their own fixed windows inside bank 0, whatever the remap and strap state.

The select and abort outputs are combinational in the address and the valid strobe. The strap and the remap bit are the only state.

Top module: `boot_remap_decoder`

## Requirements
- R1: A valid access to bank 1, 2, 3, 4, 5 or 6 (addr[31:28]) raises only the external chip-select bit sel[2+bank-1], so bank 1 gives sel[2] and bank 6 gives sel[7].
- R2: A valid access to bank 7 raises only sel[8] (DDR controller). A valid access to bank 15 raises only sel[9] (peripheral bridge).
- R3: A valid access to any bank from 8 to 14 raises abort and leaves every sel bit low.
- R4: In bank 0, the 1 MB window with addr[27:20] = 0x04 always raises sel[0] (ROM), and the window with addr[27:20] = 0x03 always raises sel[1] (SRAM), for any remap or strap state.
- R5: While remap is 0, bank 0 with addr[27:20] = 0x00 raises sel[0] (ROM) when the latched strap is 1, and sel[2] (external chip select 0) when it is 0.
- R6: While remap is 1, bank 0 with addr[27:20] = 0x00 raises sel[1] (SRAM).
- R7: A valid access to bank 0 whose addr[27:20] is not 0x00, 0x03 or 0x04 raises abort with every sel bit low.
- R8: The strap is the boot pin value at the last rising clock edge with reset high. Later changes of the pin do not change where the alias goes.
- R9: remap_o is 0 after reset. A remap_set_i pulse makes it 1 from the next clock edge, and a remap_clr_i pulse makes it 0 from the next clock edge. When both are high, clear wins. With neither high, it holds.
- R10: While valid_i is low, every sel bit and abort are low.
- R11: While valid_i is high, exactly one of the sel bits and abort is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 32 | Request address |
| valid_i | input | 1 | Request valid strobe |
| boot_pin_i | input | 1 | Boot-select level, latched during reset |
| remap_set_i | input | 1 | Single-cycle command that sets remap |
| remap_clr_i | input | 1 | Single-cycle command that clears remap |
| sel_o | output | 10 | One-hot slave select (0 ROM, 1 SRAM, 2..7 chip selects 0..5, 8 DDR, 9 peripherals) |
| abort_o | output | 1 | Decode abort for unmapped addresses |
| remap_o | output | 1 | Current remap state |

## Verification
The bench builds the decoder with its default bank-0 window positions: ROM at sub-field 0x04, SRAM at 0x03 and the alias at 0x00. These defaults put the fixed windows, the alias and the unmapped bank-0 windows all within reach of random addresses that are biased toward bank 0. The bench resets twice, once with each strap level, so both boot targets of the alias are exercised. Random remap set and clear pulses, including pulses where both are high together, move the alias between its two targets while the boot pin changes freely.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

    localparam int ADDR_W = 32;
    localparam int BANK_W = 4;
    localparam int SUB_W  = 8;
    localparam int LOW_W  = ADDR_W - BANK_W - SUB_W;
    localparam int NUM_CS = 6;

    localparam int SLV_ROM     = 0;
    localparam int SLV_SRAM    = 1;
    localparam int SLV_CS_BASE = 2;
    localparam int SLV_DDR     = SLV_CS_BASE + NUM_CS;
    localparam int SLV_PERIPH  = SLV_DDR + 1;
    localparam int NUM_SLV     = SLV_PERIPH + 1;

    localparam logic [BANK_W-1:0] BANK_INT    = 4'd0;
    localparam logic [BANK_W-1:0] BANK_DDR    = 4'd7;
    localparam logic [BANK_W-1:0] BANK_PERIPH = 4'd15;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SUB_W-1:0]  sub;
    } addr_fields_t;

    typedef struct packed {
        logic               abort;
        logic [NUM_SLV-1:0] sel;
    } dec_result_t;

    function automatic addr_fields_t split_addr(input logic [ADDR_W-1:0] a);
        addr_fields_t f;
        f.bank = a[ADDR_W-1 -: BANK_W];
        f.sub  = a[ADDR_W-BANK_W-1 -: SUB_W];
        return f;
    endfunction

    function automatic dec_result_t hit(input int idx);
        dec_result_t r;
        r = '0;
        r.sel[idx] = 1'b1;
        return r;
    endfunction

    function automatic dec_result_t miss();
        dec_result_t r;
        r = '0;
        r.abort = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic strap_o
);
    // Tracks the pin while reset is held; the last reset edge's value sticks.
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_o <= pin_i;
        end
    end
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic remap_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            remap_o <= 1'b0;
        end else if (clr_i) begin
            remap_o <= 1'b0;
        end else if (set_i) begin
            remap_o <= 1'b1;
        end
    end
endmodule

// File: rtl/bank0_decoder.sv
module bank0_decoder
    import boot_dec_pkg::*;
#(
    parameter logic [SUB_W-1:0] ALIAS_SUB = 8'h00,
    parameter logic [SUB_W-1:0] SRAM_SUB  = 8'h03,
    parameter logic [SUB_W-1:0] ROM_SUB   = 8'h04
) (
    input  logic [SUB_W-1:0] sub_i,
    input  logic             remap_i,
    input  logic             strap_i,
    output dec_result_t      res_o
);
    dec_result_t alias_res;

    always_comb begin
        if (remap_i) begin
            alias_res = hit(SLV_SRAM);
        end else if (strap_i) begin
            alias_res = hit(SLV_ROM);
        end else begin
            alias_res = hit(SLV_CS_BASE);
        end
    end

    always_comb begin
        if (sub_i == ROM_SUB) begin
            res_o = hit(SLV_ROM);
        end else if (sub_i == SRAM_SUB) begin
            res_o = hit(SLV_SRAM);
        end else if (sub_i == ALIAS_SUB) begin
            res_o = alias_res;
        end else begin
            res_o = miss();
        end
    end
endmodule

// File: rtl/bank_router.sv
module bank_router
    import boot_dec_pkg::*;
(
    input  logic [BANK_W-1:0] bank_i,
    input  dec_result_t       int_res_i,
    output dec_result_t       res_o
);
    logic [NUM_CS-1:0] cs_hit;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_hit[g] = (bank_i == BANK_W'(g + 1));
    end

    always_comb begin
        res_o = '0;
        if (bank_i == BANK_INT) begin
            res_o = int_res_i;
        end else if (bank_i == BANK_DDR) begin
            res_o = hit(SLV_DDR);
        end else if (bank_i == BANK_PERIPH) begin
            res_o = hit(SLV_PERIPH);
        end else if (|cs_hit) begin
            res_o.sel[SLV_CS_BASE +: NUM_CS] = cs_hit;
        end else begin
            res_o = miss();
        end
    end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import boot_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               valid_i,
    input  logic               boot_pin_i,
    input  logic               remap_set_i,
    input  logic               remap_clr_i,
    output logic [NUM_SLV-1:0] sel_o,
    output logic               abort_o,
    output logic               remap_o
);
    addr_fields_t fields;
    dec_result_t  int_res;
    dec_result_t  bank_res;
    logic         strap;
    logic         unused_low;

    assign fields     = split_addr(addr_i);
    assign unused_low = ^addr_i[LOW_W-1:0];

    boot_strap_latch i_strap (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (boot_pin_i),
        .strap_o(strap)
    );

    remap_ctrl i_remap (
        .clk    (clk),
        .rst    (rst),
        .set_i  (remap_set_i),
        .clr_i  (remap_clr_i),
        .remap_o(remap_o)
    );

    bank0_decoder i_bank0 (
        .sub_i  (fields.sub),
        .remap_i(remap_o),
        .strap_i(strap),
        .res_o  (int_res)
    );

    bank_router i_router (
        .bank_i   (fields.bank),
        .int_res_i(int_res),
        .res_o    (bank_res)
    );

    assign sel_o   = valid_i ? bank_res.sel : '0;
    assign abort_o = valid_i & bank_res.abort;
endmodule

// File: rtl/boot_decoder_chk.sv
module boot_decoder_chk
    import boot_dec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               valid_i,
    input logic               remap_set_i,
    input logic               remap_clr_i,
    input logic [NUM_SLV-1:0] sel_o,
    input logic               abort_o,
    input logic               remap_o
);
    // R11
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> $countones({sel_o, abort_o}) == 1);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (sel_o == '0) && !abort_o);

    // R9
    remap_set_chk: assert property (@(posedge clk) disable iff (rst)
        (remap_set_i && !remap_clr_i) |=> remap_o);

    // R9
    remap_clr_chk: assert property (@(posedge clk) disable iff (rst)
        remap_clr_i |=> !remap_o);

    // R9
    remap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!remap_set_i && !remap_clr_i) |=> $stable(remap_o));

    // R3
    hole_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && addr_i[31:28] >= 4'd8 && addr_i[31:28] <= 4'd14) |-> abort_o);

    // R4
    rom_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && addr_i[31:20] == 12'h004) |-> sel_o[SLV_ROM]);

    // R6
    alias_sram_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && addr_i[31:20] == 12'h000 && remap_o) |-> sel_o[SLV_SRAM]);
endmodule

bind boot_remap_decoder boot_decoder_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .valid_i    (valid_i),
    .remap_set_i(remap_set_i),
    .remap_clr_i(remap_clr_i),
    .sel_o      (sel_o),
    .abort_o    (abort_o),
    .remap_o    (remap_o)
);

// File: tb/test_boot_remap_decoder.sv
module test_boot_remap_decoder;
    import boot_dec_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst = 1'b1;
    logic [31:0]        addr = '0;
    logic               valid = 1'b0;
    logic               pin = 1'b1;
    logic               rset = 1'b0;
    logic               rclr = 1'b0;
    logic [NUM_SLV-1:0] sel;
    logic               abort;
    logic               remap;

    int nchk  = 0;
    int nfail = 0;
    bit remap_m = 1'b0;
    bit strap_m = 1'b1;
    bit done = 1'b0;

    boot_remap_decoder i_boot_remap_decoder (
        .clk(clk), .rst(rst), .addr_i(addr), .valid_i(valid),
        .boot_pin_i(pin), .remap_set_i(rset), .remap_clr_i(rclr),
        .sel_o(sel), .abort_o(abort), .remap_o(remap)
    );

    function automatic logic [NUM_SLV:0] expect_dec(logic [31:0] a, bit v, bit rm, bit st);
        logic [NUM_SLV:0] r;
        int b;
        int s;
        r = '0;
        b = int'(a[31:28]);
        s = int'(a[27:20]);
        if (!v) return r;
        if (b >= 1 && b <= 6)      r[SLV_CS_BASE + b - 1] = 1'b1;
        else if (b == 7)           r[SLV_DDR] = 1'b1;
        else if (b == 15)          r[SLV_PERIPH] = 1'b1;
        else if (b == 0) begin
            if (s == 4)            r[SLV_ROM] = 1'b1;
            else if (s == 3)       r[SLV_SRAM] = 1'b1;
            else if (s == 0)       r[rm ? SLV_SRAM : (st ? SLV_ROM : SLV_CS_BASE)] = 1'b1;
            else                   r[NUM_SLV] = 1'b1;
        end else                   r[NUM_SLV] = 1'b1;
        return r;
    endfunction

    function automatic string tag_of(logic [31:0] a, bit v, bit rm);
        int b;
        int s;
        b = int'(a[31:28]);
        s = int'(a[27:20]);
        if (!v) return "R10";
        if (b >= 1 && b <= 6) return "R1";
        if (b == 7 || b == 15) return "R2";
        if (b != 0) return "R3";
        if (s == 3 || s == 4) return "R4";
        if (s == 0) return rm ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic apply(logic [31:0] a, bit v, bit s, bit c, bit p, string tag);
        logic [NUM_SLV:0] exp_v;
        logic [NUM_SLV:0] got;
        string t;
        @(negedge clk);
        addr = a; valid = v; rset = s; rclr = c; pin = p;
        #5;
        exp_v = expect_dec(a, v, remap_m, strap_m);
        got = {abort, sel};
        t = (tag == "") ? tag_of(a, v, remap_m) : tag;
        nchk++;
        if (got !== exp_v) begin
            nfail++;
            $display("FAIL %s addr=%h got=%b expected=%b", t, a, got, exp_v);
        end
        nchk++;
        if (remap !== remap_m) begin
            nfail++;
            $display("FAIL R9 remap got=%b expected=%b", remap, remap_m);
        end
        if (c) remap_m = 1'b0;
        else if (s) remap_m = 1'b1;
    endtask

    task automatic do_reset(bit p);
        @(negedge clk);
        rst = 1'b1; pin = p; valid = 1'b0; rset = 1'b0; rclr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        strap_m = p;
        remap_m = 1'b0;
        #5;
        nchk++;
        if (remap !== 1'b0) begin
            nfail++;
            $display("FAIL R9 reset remap got=%b expected=0", remap);
        end
    endtask

    function automatic logic [31:0] rand_addr();
        logic [31:0] a;
        int pick;
        a = $urandom();
        pick = int'($urandom_range(0, 9));
        if (pick < 2)      a[31:20] = 12'h000;
        else if (pick < 3) a[31:20] = 12'h003;
        else if (pick < 4) a[31:20] = 12'h004;
        else if (pick < 5) a[31:28] = 4'h0;
        return a;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired got=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b1);
        apply(32'h0000_1000, 1'b0, 0, 0, 1, "R10");
        for (int b = 0; b < 16; b++) begin
            apply({b[3:0], 28'h012_3450}, 1'b1, 0, 0, 1, "");
        end
        apply(32'h0000_0000, 1'b1, 0, 0, 0, "R8");
        apply(32'h000F_FFFC, 1'b1, 0, 0, 0, "R5");
        apply(32'h0040_0000, 1'b1, 0, 0, 0, "R4");
        apply(32'h0030_0010, 1'b1, 0, 0, 0, "R4");
        apply(32'h0010_0000, 1'b1, 0, 0, 0, "R7");
        apply(32'h0FF0_0000, 1'b1, 0, 0, 0, "R7");
        apply(32'h8000_0000, 1'b1, 0, 0, 0, "R3");
        apply(32'hEFFF_FFFF, 1'b1, 1, 0, 0, "R3");
        apply(32'h0000_0040, 1'b1, 0, 0, 0, "R6");
        apply(32'h0040_0040, 1'b1, 0, 0, 0, "R4");
        apply(32'h0000_0040, 1'b1, 1, 1, 0, "R6");
        apply(32'h0000_0040, 1'b1, 0, 0, 0, "R9");
        do_reset(1'b0);
        apply(32'h0000_0000, 1'b1, 0, 0, 1, "R5");
        apply(32'h0040_0000, 1'b1, 0, 0, 1, "R4");
        apply(32'h1000_0000, 1'b1, 1, 0, 1, "R1");
        apply(32'h0000_0000, 1'b1, 0, 1, 1, "R6");
        apply(32'h0000_0000, 1'b1, 0, 0, 1, "R8");
        for (int i = 0; i < 4000; i++) begin
            apply(rand_addr(), ($urandom_range(0, 7) != 0),
                  ($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0),
                  $urandom_range(0, 1) == 1, "");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule